// File: doc/BRIEF.md
# Memory-Mapped Accumulator Core

This block is a small 8-bit processor. Its architectural state lives entirely in a 256-cell, 8-bit data memory. Cell 0 serves as the first accumulator, cell 1 as the second accumulator and cell 2 as the program counter. Because these are plain memory cells, an indirect store can overwrite any of them. Program code is held in a separate store of 256 six-bit words. Code is written through a load port while the core is halted.

Each instruction takes two clock cycles while `run_i` is high. In the first cycle the core captures the program word addressed by cell 2. In the second cycle it decodes that word, performs at most one data write and updates the program counter. Driving `run_i` low halts the core at an instruction boundary. While halted, a debug port can read and write any data cell, and a test harness uses it to set up state and inspect results one instruction at a time.

Top module: `acc_cpu`

## Requirements
- R1: An active-low reset clears all 256 data cells to zero and holds `retire_o` low, so execution restarts at program address 0. Program contents are kept across reset.
- R2: A program-load write or a debug write takes effect only while the core is halted, meaning `run_i` is low and no instruction is in flight. While running, both are ignored and leave data and program unchanged.
- R3: With `run_i` high, each instruction takes exactly two rising edges. `retire_o` is high for one cycle after the edge that updates state. With `run_i` low, no state changes except through the ports in R2.
- R4: Code 100000 writes (acc1+acc2) mod 256 to cell 0. Code 100001 writes NOT(acc1 AND acc2) to cell 0. Code 100010 writes NOT(acc1 XOR acc2) to cell 0.
- R5: Code 110000 loads the program counter with acc2 when acc1 is nonzero. Otherwise it increments the program counter.
- R6: Code 111110 writes acc1 into the cell addressed by acc2.
- R7: Code 111111 writes into cell 0 the value of the cell addressed by acc2.
- R8: Code 00kkkk replaces bits 3:0 of acc1 with k and keeps bits 7:4. Code 01kkkk replaces bits 7:4 with k and keeps bits 3:0.
- R9: For every code except 110000, the program counter becomes the value of cell 2 after the data write, plus one. A store aimed at cell 2 therefore leaves the stored value plus one.
- R10: Any code not listed in R4 to R8 changes nothing except the program counter increment.
- R11: The program counter wraps from 255 to 0.
- R12: `dbg_rdata_o` shows the current content of the cell addressed by `dbg_addr_i` in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Execute instructions while high; halt at the next boundary when low |
| retire_o | output | 1 | One-cycle pulse after an instruction has updated state |
| pload_en_i | input | 1 | Program word write strobe (halted only) |
| pload_addr_i | input | 8 | Program word address |
| pload_data_i | input | 6 | Program word value |
| dbg_addr_i | input | 8 | Debug data-cell address |
| dbg_we_i | input | 1 | Debug data-cell write strobe (halted only) |
| dbg_wdata_i | input | 8 | Debug write value |
| dbg_rdata_o | output | 8 | Content of the addressed data cell |

## Verification
The bound checker verifies the following on every cycle:
- the two-cycle fetch and retire rhythm;
- the program counter increment with wrap for non-jump codes;
- the taken jump target;
- the add result;
- the low-nibble literal insert.

Some behaviours can only be shown by the bench's scenarios. These are the indirect store and load through acc2, a store that overwrites the program counter, undefined codes, and loads or debug writes that are ignored while running. The bench compares the whole data memory against a reference model after each single step.

// File: rtl/acc_cpu_pkg.sv
`timescale 1ns/1ps
package acc_cpu_pkg;
  localparam int unsigned INSTR_W = 6;
  localparam int unsigned ACC1_ADDR = 0;
  localparam int unsigned ACC2_ADDR = 1;
  localparam int unsigned PC_ADDR   = 2;

  localparam logic [INSTR_W-1:0] OP_ADD  = 6'b100000;
  localparam logic [INSTR_W-1:0] OP_NAND = 6'b100001;
  localparam logic [INSTR_W-1:0] OP_XNOR = 6'b100010;
  localparam logic [INSTR_W-1:0] OP_JNZ  = 6'b110000;
  localparam logic [INSTR_W-1:0] OP_STI  = 6'b111110;
  localparam logic [INSTR_W-1:0] OP_LDI  = 6'b111111;
endpackage

// File: rtl/acc_cpu_pmem.sv
`timescale 1ns/1ps
module acc_cpu_pmem #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned WORD_W = 6
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/acc_cpu_dmem.sv
`timescale 1ns/1ps
module acc_cpu_dmem
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pc_we_i,
  input  logic [DATA_W-1:0] pc_wdata_i,
  input  logic [DATA_W-1:0] ind_addr_i,
  output logic [DATA_W-1:0] ind_data_o,
  input  logic [DATA_W-1:0] dbg_addr_i,
  output logic [DATA_W-1:0] dbg_data_o,
  output logic [DATA_W-1:0] acc1_o,
  output logic [DATA_W-1:0] acc2_o,
  output logic [DATA_W-1:0] pc_o
);
  localparam int unsigned DEPTH = 1 << DATA_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // pc update is applied after the data write so it wins on cell 2
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (we_i)    mem_q[waddr_i] <= wdata_i;
      if (pc_we_i) mem_q[PC_ADDR] <= pc_wdata_i;
    end
  end

  assign ind_data_o = mem_q[ind_addr_i];
  assign dbg_data_o = mem_q[dbg_addr_i];
  assign acc1_o     = mem_q[ACC1_ADDR];
  assign acc2_o     = mem_q[ACC2_ADDR];
  assign pc_o       = mem_q[PC_ADDR];
endmodule

// File: rtl/acc_cpu_exec.sv
`timescale 1ns/1ps
module acc_cpu_exec
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  acc1_i,
  input  logic [DATA_W-1:0]  acc2_i,
  input  logic [DATA_W-1:0]  pc_i,
  input  logic [DATA_W-1:0]  ind_data_i,
  output logic               we_o,
  output logic [DATA_W-1:0]  waddr_o,
  output logic [DATA_W-1:0]  wdata_o,
  output logic [DATA_W-1:0]  pc_next_o
);
  localparam int unsigned NIB = DATA_W / 2;

  logic is_jump;

  always_comb begin
    we_o    = 1'b0;
    waddr_o = DATA_W'(ACC1_ADDR);
    wdata_o = acc1_i;
    is_jump = 1'b0;
    casez (instr_i)
      6'b00????: begin we_o = 1'b1; wdata_o = {acc1_i[DATA_W-1:NIB], instr_i[NIB-1:0]}; end
      6'b01????: begin we_o = 1'b1; wdata_o = {instr_i[NIB-1:0], acc1_i[NIB-1:0]}; end
      OP_ADD:    begin we_o = 1'b1; wdata_o = acc1_i + acc2_i; end
      OP_NAND:   begin we_o = 1'b1; wdata_o = ~(acc1_i & acc2_i); end
      OP_XNOR:   begin we_o = 1'b1; wdata_o = ~(acc1_i ^ acc2_i); end
      OP_STI:    begin we_o = 1'b1; waddr_o = acc2_i; end
      OP_LDI:    begin we_o = 1'b1; wdata_o = ind_data_i; end
      OP_JNZ:    is_jump = 1'b1;
      default:   ;
    endcase
  end

  // sequential semantics: increment reads cell 2 as left by the data write
  always_comb begin
    if (is_jump)
      pc_next_o = (acc1_i != '0) ? acc2_i : pc_i + DATA_W'(1);
    else if (we_o && waddr_o == DATA_W'(PC_ADDR))
      pc_next_o = wdata_o + DATA_W'(1);
    else
      pc_next_o = pc_i + DATA_W'(1);
  end
endmodule

// File: rtl/acc_cpu.sv
`timescale 1ns/1ps
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  output logic               retire_o,
  input  logic               pload_en_i,
  input  logic [DATA_W-1:0]  pload_addr_i,
  input  logic [INSTR_W-1:0] pload_data_i,
  input  logic [DATA_W-1:0]  dbg_addr_i,
  input  logic               dbg_we_i,
  input  logic [DATA_W-1:0]  dbg_wdata_i,
  output logic [DATA_W-1:0]  dbg_rdata_o
);
  logic               phase_q;
  logic               retire_q;
  logic [INSTR_W-1:0] instr_q;
  logic [INSTR_W-1:0] fetch_word;
  logic [DATA_W-1:0]  acc1, acc2, pc, ind_data;
  logic               ex_we;
  logic [DATA_W-1:0]  ex_waddr, ex_wdata, ex_pc_next;
  logic               idle;
  logic               mem_we;
  logic [DATA_W-1:0]  mem_waddr, mem_wdata;

  assign idle = !phase_q && !run_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= 1'b0;
      retire_q <= 1'b0;
      instr_q  <= '0;
    end else begin
      retire_q <= phase_q;
      if (phase_q) begin
        phase_q <= 1'b0;
      end else if (run_i) begin
        phase_q <= 1'b1;
        instr_q <= fetch_word;
      end
    end
  end

  assign retire_o = retire_q;

  acc_cpu_pmem #(.ADDR_W(DATA_W), .WORD_W(INSTR_W)) u_pmem (
    .clk_i   (clk_i),
    .we_i    (pload_en_i && idle),
    .waddr_i (pload_addr_i),
    .wdata_i (pload_data_i),
    .raddr_i (pc),
    .rdata_o (fetch_word)
  );

  acc_cpu_exec #(.DATA_W(DATA_W)) u_exec (
    .instr_i    (instr_q),
    .acc1_i     (acc1),
    .acc2_i     (acc2),
    .pc_i       (pc),
    .ind_data_i (ind_data),
    .we_o       (ex_we),
    .waddr_o    (ex_waddr),
    .wdata_o    (ex_wdata),
    .pc_next_o  (ex_pc_next)
  );

  assign mem_we    = phase_q ? ex_we    : (dbg_we_i && idle);
  assign mem_waddr = phase_q ? ex_waddr : dbg_addr_i;
  assign mem_wdata = phase_q ? ex_wdata : dbg_wdata_i;

  acc_cpu_dmem #(.DATA_W(DATA_W)) u_dmem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (mem_we),
    .waddr_i    (mem_waddr),
    .wdata_i    (mem_wdata),
    .pc_we_i    (phase_q),
    .pc_wdata_i (ex_pc_next),
    .ind_addr_i (acc2),
    .ind_data_o (ind_data),
    .dbg_addr_i (dbg_addr_i),
    .dbg_data_o (dbg_rdata_o),
    .acc1_o     (acc1),
    .acc2_o     (acc2),
    .pc_o       (pc)
  );
endmodule

// File: rtl/acc_cpu_chk.sv
`timescale 1ns/1ps
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               phase_q,
  input logic               retire_o,
  input logic [INSTR_W-1:0] instr_q,
  input logic [DATA_W-1:0]  acc1,
  input logic [DATA_W-1:0]  acc2,
  input logic [DATA_W-1:0]  pc
);
  localparam int unsigned NIB = DATA_W / 2;

  a_r3_retire_follows_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q |=> retire_o);

  a_r3_retire_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |=> !retire_o);

  a_r4_add_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q && instr_q == OP_ADD |=> acc1 == DATA_W'($past(acc1) + $past(acc2)));

  a_r5_jump_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q && instr_q == OP_JNZ && acc1 != '0 |=> pc == $past(acc2));

  a_r8_low_nibble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q && instr_q[5:4] == 2'b00 |=>
      acc1[NIB-1:0] == $past(instr_q[NIB-1:0]) && acc1[DATA_W-1:NIB] == $past(acc1[DATA_W-1:NIB]));

  a_r11_pc_increment_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q && instr_q != OP_JNZ && !(instr_q == OP_STI && acc2 == DATA_W'(PC_ADDR))
      |=> pc == DATA_W'($past(pc) + DATA_W'(1)));
endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .phase_q  (phase_q),
  .retire_o (retire_o),
  .instr_q  (instr_q),
  .acc1     (acc1),
  .acc2     (acc2),
  .pc       (pc)
);

// File: tb/acc_cpu_tb_top.sv
`timescale 1ns/1ps
module acc_cpu_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       run_i = 1'b0;
  logic       retire_o;
  logic       pload_en_i = 1'b0;
  logic [7:0] pload_addr_i = '0;
  logic [5:0] pload_data_i = '0;
  logic [7:0] dbg_addr_i = '0;
  logic       dbg_we_i = 1'b0;
  logic [7:0] dbg_wdata_i = '0;
  logic [7:0] dbg_rdata_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [7:0] m [256];
  logic [5:0] p [256];

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  acc_cpu dut_i (
    .clk_i, .rst_ni, .run_i, .retire_o,
    .pload_en_i, .pload_addr_i, .pload_data_i,
    .dbg_addr_i, .dbg_we_i, .dbg_wdata_i, .dbg_rdata_o
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic prog_write(int a, logic [5:0] d);
    @(negedge clk_i);
    pload_en_i = 1'b1; pload_addr_i = 8'(a); pload_data_i = d;
    @(negedge clk_i);
    pload_en_i = 1'b0;
    p[a] = d;
  endtask

  task automatic dbg_write(int a, logic [7:0] d);
    @(negedge clk_i);
    dbg_we_i = 1'b1; dbg_addr_i = 8'(a); dbg_wdata_i = d;
    @(negedge clk_i);
    dbg_we_i = 1'b0;
    m[a] = d;
  endtask

  task automatic compare_all(string tag);
    int bad = -1;
    int act = 0;
    for (int i = 0; i < 256; i++) begin
      dbg_addr_i = 8'(i);
      #1;
      if (dbg_rdata_o !== m[i] && bad < 0) begin bad = i; act = int'(dbg_rdata_o); end
    end
    check(bad < 0, tag, $sformatf("data cell %0d", bad), act, (bad < 0) ? 0 : int'(m[bad]));
  endtask

  // reference semantics of one instruction
  task automatic model_exec();
    logic [7:0] a1, a2, pcv;
    logic [5:0] ins;
    a1 = m[0]; a2 = m[1]; pcv = m[2]; ins = p[pcv];
    if (ins == 6'b110000) begin
      m[2] = (a1 != 0) ? a2 : 8'(pcv + 1);
    end else begin
      if (ins[5:4] == 2'b00)      m[0] = {a1[7:4], ins[3:0]};
      else if (ins[5:4] == 2'b01) m[0] = {ins[3:0], a1[3:0]};
      else if (ins == 6'b100000)  m[0] = 8'(a1 + a2);
      else if (ins == 6'b100001)  m[0] = ~(a1 & a2);
      else if (ins == 6'b100010)  m[0] = ~(a1 ^ a2);
      else if (ins == 6'b111110)  m[a2] = a1;
      else if (ins == 6'b111111)  m[0] = m[a2];
      m[2] = 8'(m[2] + 1);
    end
  endtask

  function automatic string tag_of(logic [5:0] ins, logic [7:0] pcv, logic [7:0] a2);
    if (ins == 6'b111110 && a2 == 8'd2) return "R9";
    if (ins != 6'b110000 && pcv == 8'hFF) return "R11";
    if (ins[5] == 1'b0) return "R8";
    case (ins)
      6'b100000, 6'b100001, 6'b100010: return "R4";
      6'b110000: return "R5";
      6'b111110: return "R6";
      6'b111111: return "R7";
      default:   return "R10";
    endcase
  endfunction

  task automatic step(string tag_in, bit disturb);
    string tag;
    tag = (tag_in != "") ? tag_in : tag_of(p[m[2]], m[2], m[1]);
    if (disturb) p[m[2]] = p[m[2]];
    model_exec();
    @(negedge clk_i);
    run_i = 1'b1;
    if (disturb) begin
      pload_en_i = 1'b1; pload_addr_i = m[2]; pload_data_i = ~p[m[2]];
      dbg_we_i = 1'b1; dbg_addr_i = 8'd1; dbg_wdata_i = ~m[1];
    end
    @(posedge clk_i); #1;
    check(retire_o == 1'b0, "R3", "retire after fetch edge", int'(retire_o), 0);
    @(posedge clk_i); #1;
    check(retire_o == 1'b1, "R3", "retire after exec edge", int'(retire_o), 1);
    @(negedge clk_i);
    run_i = 1'b0; pload_en_i = 1'b0; dbg_we_i = 1'b0;
    compare_all(tag);
  endtask

  function automatic logic [5:0] rand_op();
    case ($urandom_range(0, 9))
      0: return 6'b100000;
      1: return 6'b100001;
      2: return 6'b100010;
      3: return 6'b110000;
      4, 9: return 6'b111110;
      5: return 6'b111111;
      6: return {2'b00, 4'($urandom)};
      7: return {2'b01, 4'($urandom)};
      default: return 6'($urandom);
    endcase
  endfunction

  initial begin
    wait (cyc == 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin m[i] = '0; p[i] = 6'b100011; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check(retire_o == 1'b0, "R1", "retire after reset", int'(retire_o), 0);
    compare_all("R1");

    // directed program, undefined filler everywhere else
    for (int i = 0; i < 256; i++) prog_write(i, 6'b100011);
    prog_write(0, 6'b000101);
    prog_write(1, 6'b011100);
    prog_write(2, 6'b100000);
    prog_write(3, 6'b100001);
    prog_write(4, 6'b100010);
    prog_write(5, 6'b110000);
    prog_write(6, 6'b001001);
    prog_write(7, 6'b110000);
    prog_write(8'h3A, 6'b111110);
    prog_write(8'h3B, 6'b111111);
    prog_write(8'h3C, 6'b100011);
    prog_write(8'h3D, 6'b111110);
    prog_write(8'h91, 6'b110001);
    prog_write(8'hFF, 6'b110001);

    step("R8", 0);                               // acc1 = 05
    check(m[0] == 8'h05, "R8", "model low nibble", int'(m[0]), 5);
    step("R8", 0);                               // acc1 = C5
    dbg_write(1, 8'h3A);
    compare_all("R12");
    step("R4", 0);                               // C5 + 3A = FF
    check(m[0] == 8'hFF, "R4", "model add", int'(m[0]), 255);
    step("R4", 0);                               // nand -> C5
    step("R4", 0);                               // xnor -> 00
    step("R5", 0);                               // not taken, pc 6
    step("R8", 0);                               // acc1 = 09
    step("R5", 0);                               // taken, pc 3A
    check(m[2] == 8'h3A, "R5", "model jump target", int'(m[2]), 58);
    step("R6", 0);                               // cell 3A = 09
    dbg_write(0, 8'h00);
    step("R7", 0);                               // acc1 = cell 3A
    step("R10", 0);
    dbg_write(1, 8'h02);
    dbg_write(0, 8'h90);
    step("R9", 0);                               // store to pc, pc = 91
    check(m[2] == 8'h91, "R9", "model store to pc", int'(m[2]), 145);
    step("R2", 1);                               // loads while running ignored
    dbg_write(2, 8'hFF);
    step("R11", 0);                              // wrap to 0
    repeat (5) @(negedge clk_i);
    compare_all("R3");                           // halted: no change
    dbg_write(200, 8'hA5);
    dbg_addr_i = 8'd200; #1;
    check(dbg_rdata_o == 8'hA5, "R12", "debug readback", int'(dbg_rdata_o), 165);

    // random programs and states
    for (int i = 0; i < 256; i++) prog_write(i, rand_op());
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 2) == 0) begin
        case ($urandom_range(0, 3))
          0: dbg_write(1, 8'd2);
          1: dbg_write(1, 8'($urandom_range(0, 3)));
          default: dbg_write(1, 8'($urandom));
        endcase
      end
      if ($urandom_range(0, 3) == 0) dbg_write(0, ($urandom_range(0, 1) == 0) ? 8'h00 : 8'($urandom));
      if ($urandom_range(0, 15) == 0) dbg_write(2, 8'hFF);
      step("", $urandom_range(0, 4) == 0);
    end

    // reset keeps program, clears data
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < 256; i++) m[i] = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    compare_all("R1");
    step("R1", 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule